// File: doc/BRIEF.md
# Pending Interrupt Priority Arbiter

This block keeps a register of pending asynchronous interrupt sources and, each time the core asks for one, picks the single source that may be taken. Each source has a fixed rank. Each source also has its own gating rule, built from the current machine state: the external-enable, critical-enable, hypervisor and problem-state bits, plus a set of partition control bits. The block returns the winner's code with a one-cycle valid pulse. For sources that clear on delivery, it removes the pending bit in the same clock edge. Level-style sources stay pending until their owner lowers them.

A core that wakes from a power-saving state sets the resume flag. While that flag is high, the asynchronous sources are allowed through even with external-enable low. If a request made in that state finds nothing that qualifies, the block raises a one-cycle error pulse instead of a grant, because the wake-up has no interrupt to deliver. The register that sets up the exception itself lies outside this block.

Top module: `irq_arbiter`

## Requirements
- R1: Source codes follow rank, highest first: 0 reset, 1 machine check, 2 hypervisor decrementer, 3 hypervisor virtualization, 4 external, 5 critical external, 6 watchdog, 7 critical doorbell, 8 fixed-interval timer, 9 programmable-interval timer, 10 decrementer, 11 doorbell, 12 hypervisor doorbell, 13 performance monitor, 14 thermal. Bit n of raise_i and lower_i is source n. When several sources qualify, the lowest code is granted.
- R2: Reset (code 0) and machine check (code 1) are granted whenever they are pending, whatever the gating inputs.
- R3: The asynchronous condition is ee_i OR resume_i. Codes 6 to 14 qualify only under it.
- R4: Code 2 qualifies when hdec_en_i=1 and (the asynchronous condition holds or hv_i=0). Code 3 follows the same rule with hvirt_en_i.
- R5: Code 4 qualifies when either of two conditions holds. The first is that the asynchronous condition holds and the block condition (ext_hv_blk_i=1, hv_i=1, pr_i=0) is false. The second is has_hv_i=1, hv_i=0 and part_env_i=0.
- R6: Code 5 qualifies when ce_i=1, regardless of every other gating input.
- R7: Delivery clears the pending bit of every source except codes 3, 4 and 5, which stay pending. Code 10 is cleared only when dec_clr_i=1.
- R8: A grant appears on grant_vld_o for exactly one cycle, one clock after a cycle with req_i=1. No grant appears without a request.
- R9: If req_i=1 and resume_i=1 and no source qualifies, wake_err_o pulses one cycle later and grant_vld_o stays low.
- R10: When nothing qualifies, grant_vld_o stays low. pend_any_o is high exactly when at least one pending bit is set. After reset both are low.
- R11: A raise_i bit sets its pending bit at the next edge and takes precedence over a delivery clear in the same cycle. A lower_i bit clears its pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raise_i | input | 15 | Per-source set of the pending bit |
| lower_i | input | 15 | Per-source clear of the pending bit |
| req_i | input | 1 | Request to select one interrupt |
| ee_i | input | 1 | External-enable state bit |
| ce_i | input | 1 | Critical-enable state bit |
| hv_i | input | 1 | Current hypervisor state bit |
| pr_i | input | 1 | Current problem-state bit |
| resume_i | input | 1 | Waking from power save, deliver as reset |
| hdec_en_i | input | 1 | Hypervisor decrementer enable |
| hvirt_en_i | input | 1 | Hypervisor virtualization enable |
| ext_hv_blk_i | input | 1 | External input blocked while in hypervisor state |
| part_env_i | input | 1 | Externals stay with the guest when set |
| has_hv_i | input | 1 | Hypervisor mode is present |
| dec_clr_i | input | 1 | Decrementer clears on delivery |
| grant_vld_o | output | 1 | One-cycle grant pulse |
| grant_code_o | output | 4 | Code of the granted source |
| wake_err_o | output | 1 | Wake request with nothing deliverable |
| pend_any_o | output | 1 | Some pending bit is set |

## Verification
The vector table loads pending patterns that pit neighbouring ranks against each other: all sources at once, pairs such as critical against watchdog, and decrementer against doorbell. Each pattern runs under gating that enables one path and disables the others. Every vector makes two requests in a row. The second request shows, at the ports, whether the first delivery cleared its source: a repeat of the same code means the source stayed pending, and the next code down means it was cleared. The vectors for the external input split its two qualifying paths and the hypervisor block condition. The decrementer vectors separate its two clear settings. The directed tests cover a raise and a delivery clear in the same cycle, lower_i acting on a level source, requests with nothing pending, and a resume with nothing deliverable.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int NUM_SRC = 15;
  localparam int SRC_W   = $clog2(NUM_SRC);

  localparam int S_RESET = 0;
  localparam int S_MCHK  = 1;
  localparam int S_HDEC  = 2;
  localparam int S_HVIRT = 3;
  localparam int S_EXT   = 4;
  localparam int S_CEXT  = 5;
  localparam int S_WDT   = 6;
  localparam int S_CDBL  = 7;
  localparam int S_FIT   = 8;
  localparam int S_PIT   = 9;
  localparam int S_DEC   = 10;
  localparam int S_DBL   = 11;
  localparam int S_HDBL  = 12;
  localparam int S_PERF  = 13;
  localparam int S_THERM = 14;

  // first source gated only by the async condition
  localparam int S_ASYNC_LO = S_WDT;

  // sources that remain pending after delivery
  localparam logic [NUM_SRC-1:0] STICKY_MASK =
    NUM_SRC'((1 << S_HVIRT) | (1 << S_EXT) | (1 << S_CEXT));

  typedef struct packed {
    logic ee;
    logic ce;
    logic hv;
    logic pr;
    logic resume;
    logic hdec_en;
    logic hvirt_en;
    logic ext_hv_blk;
    logic part_env;
    logic has_hv;
    logic dec_clr;
  } gate_t;
endpackage

// File: rtl/irq_pend_store.sv
module irq_pend_store #(
  parameter int N = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] raise_i,
  input  logic [N-1:0] lower_i,
  input  logic [N-1:0] dlv_clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  // raise dominates both clear paths
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~lower_i & ~dlv_clr_i) | raise_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_gate.sv
module irq_gate
  import irq_arb_pkg::*;
(
  input  logic [NUM_SRC-1:0] pend_i,
  input  gate_t              gate_i,
  output logic [NUM_SRC-1:0] elig_o,
  output logic [NUM_SRC-1:0] clr_ok_o
);
  logic async_ok;
  logic hv_path_ok;
  logic ext_blocked;
  logic ext_to_hv;

  always_comb begin
    async_ok    = gate_i.ee | gate_i.resume;
    hv_path_ok  = async_ok | ~gate_i.hv;
    ext_blocked = gate_i.ext_hv_blk & gate_i.hv & ~gate_i.pr;
    ext_to_hv   = gate_i.has_hv & ~gate_i.hv & ~gate_i.part_env;

    elig_o          = '0;
    elig_o[S_RESET] = pend_i[S_RESET];
    elig_o[S_MCHK]  = pend_i[S_MCHK];
    elig_o[S_HDEC]  = pend_i[S_HDEC]  & gate_i.hdec_en  & hv_path_ok;
    elig_o[S_HVIRT] = pend_i[S_HVIRT] & gate_i.hvirt_en & hv_path_ok;
    elig_o[S_EXT]   = pend_i[S_EXT] & ((async_ok & ~ext_blocked) | ext_to_hv);
    elig_o[S_CEXT]  = pend_i[S_CEXT] & gate_i.ce;
    for (int i = S_ASYNC_LO; i < NUM_SRC; i++) begin
      elig_o[i] = pend_i[i] & async_ok;
    end

    clr_ok_o        = ~STICKY_MASK;
    clr_ok_o[S_DEC] = gate_i.dec_clr;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N  = 15,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  elig_i,
  output logic [N-1:0]  onehot_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  // lowest index wins
  always_comb begin
    onehot_o = '0;
    idx_o    = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig_i[i]) begin
        onehot_o    = '0;
        onehot_o[i] = 1'b1;
        idx_o       = IW'(i);
      end
    end
    any_o = |elig_i;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_arb_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] raise_i,
  input  logic [NUM_SRC-1:0] lower_i,
  input  logic               req_i,
  input  logic               ee_i,
  input  logic               ce_i,
  input  logic               hv_i,
  input  logic               pr_i,
  input  logic               resume_i,
  input  logic               hdec_en_i,
  input  logic               hvirt_en_i,
  input  logic               ext_hv_blk_i,
  input  logic               part_env_i,
  input  logic               has_hv_i,
  input  logic               dec_clr_i,
  output logic               grant_vld_o,
  output logic [SRC_W-1:0]   grant_code_o,
  output logic               wake_err_o,
  output logic               pend_any_o
);
  gate_t              gate;
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] elig;
  logic [NUM_SRC-1:0] clr_ok;
  logic [NUM_SRC-1:0] win_oh;
  logic [NUM_SRC-1:0] dlv_clr;
  logic [SRC_W-1:0]   win_idx;
  logic               win_any;

  always_comb begin
    gate.ee         = ee_i;
    gate.ce         = ce_i;
    gate.hv         = hv_i;
    gate.pr         = pr_i;
    gate.resume     = resume_i;
    gate.hdec_en    = hdec_en_i;
    gate.hvirt_en   = hvirt_en_i;
    gate.ext_hv_blk = ext_hv_blk_i;
    gate.part_env   = part_env_i;
    gate.has_hv     = has_hv_i;
    gate.dec_clr    = dec_clr_i;
  end

  irq_pend_store #(.N(NUM_SRC)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .raise_i   (raise_i),
    .lower_i   (lower_i),
    .dlv_clr_i (dlv_clr),
    .pend_o    (pend_q)
  );

  irq_gate u_gate (
    .pend_i   (pend_q),
    .gate_i   (gate),
    .elig_o   (elig),
    .clr_ok_o (clr_ok)
  );

  irq_prio_pick #(.N(NUM_SRC)) u_pick (
    .elig_i   (elig),
    .onehot_o (win_oh),
    .idx_o    (win_idx),
    .any_o    (win_any)
  );

  assign dlv_clr = req_i ? (win_oh & clr_ok) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_vld_o  <= 1'b0;
      grant_code_o <= '0;
      wake_err_o   <= 1'b0;
    end else begin
      grant_vld_o <= req_i & win_any;
      wake_err_o  <= req_i & ~win_any & resume_i;
      if (req_i && win_any) grant_code_o <= win_idx;
    end
  end

  assign pend_any_o = |pend_q;
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk
  import irq_arb_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic               resume_i,
  input logic [NUM_SRC-1:0] raise_i,
  input logic [NUM_SRC-1:0] lower_i,
  input logic [NUM_SRC-1:0] pend_q,
  input logic               grant_vld_o,
  input logic [SRC_W-1:0]   grant_code_o,
  input logic               wake_err_o
);
  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_vld_o |-> $past(req_i)); // R8

  AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_vld_o |-> (int'(grant_code_o) < NUM_SRC)); // R1

  AST_RESET_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && pend_q[S_RESET]) |=> (grant_vld_o && grant_code_o == SRC_W'(S_RESET))); // R2

  AST_RESET_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_vld_o && grant_code_o == SRC_W'(S_RESET) && !$past(raise_i[S_RESET]))
      |-> !pend_q[S_RESET]); // R7

  AST_HVIRT_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_vld_o && grant_code_o == SRC_W'(S_HVIRT) && !$past(lower_i[S_HVIRT]))
      |-> pend_q[S_HVIRT]); // R7

  AST_RAISE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|raise_i) |=> ((pend_q & $past(raise_i)) == $past(raise_i))); // R11

  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_err_o |-> ($past(req_i) && $past(resume_i))); // R9

  AST_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wake_err_o && grant_vld_o)); // R9
endmodule

bind irq_arbiter irq_arbiter_chk u_chk (.*);

// File: tb/tb_irq_arbiter.sv
`timescale 1ns/100ps
module tb_irq_arbiter;
  localparam int NS = 15;
  localparam int NV = 22;

  // gate bit positions inside a table entry
  localparam int G_EE = 0, G_CE = 1, G_HV = 2, G_PR = 3, G_RES = 4, G_HDE = 5,
                 G_HVE = 6, G_BLK = 7, G_PENV = 8, G_HAS = 9, G_DCLR = 10;

  typedef struct packed {
    logic [14:0] rs;
    logic [10:0] g;
    logic        v1; logic [3:0] c1; logic e1;
    logic        v2; logic [3:0] c2; logic e2;
  } vec_t;

  localparam logic [37:0] VECS [NV] = '{
    {15'h7FFF, 11'h001, 1'b1, 4'd0,  1'b0, 1'b1, 4'd1,  1'b0},
    {15'h4002, 11'h000, 1'b1, 4'd1,  1'b0, 1'b0, 4'd0,  1'b0},
    {15'h0004, 11'h020, 1'b1, 4'd2,  1'b0, 1'b0, 4'd0,  1'b0},
    {15'h0004, 11'h024, 1'b0, 4'd0,  1'b0, 1'b0, 4'd0,  1'b0},
    {15'h0008, 11'h041, 1'b1, 4'd3,  1'b0, 1'b1, 4'd3,  1'b0},
    {15'h0010, 11'h085, 1'b0, 4'd0,  1'b0, 1'b0, 4'd0,  1'b0},
    {15'h0010, 11'h08D, 1'b1, 4'd4,  1'b0, 1'b1, 4'd4,  1'b0},
    {15'h0010, 11'h200, 1'b1, 4'd4,  1'b0, 1'b1, 4'd4,  1'b0},
    {15'h0010, 11'h300, 1'b0, 4'd0,  1'b0, 1'b0, 4'd0,  1'b0},
    {15'h0060, 11'h002, 1'b1, 4'd5,  1'b0, 1'b1, 4'd5,  1'b0},
    {15'h0060, 11'h001, 1'b1, 4'd6,  1'b0, 1'b0, 4'd0,  1'b0},
    {15'h0C00, 11'h001, 1'b1, 4'd10, 1'b0, 1'b1, 4'd10, 1'b0},
    {15'h0C00, 11'h401, 1'b1, 4'd10, 1'b0, 1'b1, 4'd11, 1'b0},
    {15'h7FC0, 11'h001, 1'b1, 4'd6,  1'b0, 1'b1, 4'd7,  1'b0},
    {15'h0300, 11'h001, 1'b1, 4'd8,  1'b0, 1'b1, 4'd9,  1'b0},
    {15'h6000, 11'h010, 1'b1, 4'd13, 1'b0, 1'b1, 4'd14, 1'b0},
    {15'h0020, 11'h010, 1'b0, 4'd0,  1'b1, 1'b0, 4'd0,  1'b1},
    {15'h0000, 11'h000, 1'b0, 4'd0,  1'b0, 1'b0, 4'd0,  1'b0},
    {15'h3000, 11'h001, 1'b1, 4'd12, 1'b0, 1'b1, 4'd13, 1'b0},
    {15'h0800, 11'h001, 1'b1, 4'd11, 1'b0, 1'b0, 4'd0,  1'b0},
    {15'h0004, 11'h025, 1'b1, 4'd2,  1'b0, 1'b0, 4'd0,  1'b0},
    {15'h0004, 11'h001, 1'b0, 4'd0,  1'b0, 1'b0, 4'd0,  1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] raise = '0, lower = '0;
  logic req = 1'b0;
  logic [10:0] g = '0;
  logic vld, err, pany;
  logic [3:0] code;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  string tags [NV];

  always #2.5 clk = ~clk;

  irq_arbiter dut (
    .clk_i(clk), .rst_ni(rst_n), .raise_i(raise), .lower_i(lower), .req_i(req),
    .ee_i(g[G_EE]), .ce_i(g[G_CE]), .hv_i(g[G_HV]), .pr_i(g[G_PR]),
    .resume_i(g[G_RES]), .hdec_en_i(g[G_HDE]), .hvirt_en_i(g[G_HVE]),
    .ext_hv_blk_i(g[G_BLK]), .part_env_i(g[G_PENV]), .has_hv_i(g[G_HAS]),
    .dec_clr_i(g[G_DCLR]),
    .grant_vld_o(vld), .grant_code_o(code), .wake_err_o(err), .pend_any_o(pany)
  );

  task automatic chk(input int act, input int exp, input string tag, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic flush();
    raise = '0; req = 1'b0; lower = '1; tick(); lower = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tags = '{"R1","R2","R4","R4","R7","R5","R5","R5","R5","R6","R3",
             "R7","R7","R1","R1","R3","R9","R10","R1","R7","R4","R4"};
    tick(); tick();
    // reset state
    chk(vld, 0, "R8", "vld in reset");
    chk(err, 0, "R9", "err in reset");
    chk(pany, 0, "R10", "pend_any in reset");
    rst_n = 1'b1; tick();
    chk(pany, 0, "R10", "pend_any after reset");

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = vec_t'(VECS[i]);
      flush();
      raise = v.rs; tick(); raise = '0;
      chk(pany, int'(|v.rs), "R10", $sformatf("pend_any vec %0d", i));
      g = v.g; req = 1'b1; tick();
      chk(vld, v.v1, tags[i], $sformatf("vld1 vec %0d", i));
      if (v.v1) chk(code, v.c1, tags[i], $sformatf("code1 vec %0d", i));
      chk(err, v.e1, tags[i], $sformatf("err1 vec %0d", i));
      tick();
      chk(vld, v.v2, tags[i], $sformatf("vld2 vec %0d", i));
      if (v.v2) chk(code, v.c2, tags[i], $sformatf("code2 vec %0d", i));
      chk(err, v.e2, tags[i], $sformatf("err2 vec %0d", i));
      req = 1'b0; g = '0;
    end

    // R8: no grant without request, single pulse per request
    flush();
    raise = 15'h0001; tick(); raise = '0;
    tick();
    chk(vld, 0, "R8", "no req no grant");
    req = 1'b1; tick(); req = 1'b0;
    chk(vld, 1, "R8", "grant after req");
    chk(code, 0, "R8", "grant code");
    tick();
    chk(vld, 0, "R8", "pulse ends");
    chk(pany, 0, "R10", "nothing left pending");

    // R11: raise in the delivery cycle keeps watchdog pending
    flush();
    g = 11'h001;
    raise = 15'h0040; tick();
    req = 1'b1; tick();
    raise = '0; tick(); req = 1'b0;
    chk(vld, 1, "R11", "watchdog regranted");
    chk(code, 6, "R11", "watchdog code");
    tick();
    chk(pany, 0, "R11", "watchdog cleared after last grant");

    // R11: lower removes a level source
    flush();
    g = 11'h041;
    raise = 15'h0008; tick(); raise = '0;
    lower = 15'h0008; tick(); lower = '0;
    chk(pany, 0, "R11", "pend_any after lower");
    req = 1'b1; tick(); req = 1'b0;
    chk(vld, 0, "R11", "lowered source not granted");
    g = '0;

    // R9: no resume, nothing deliverable -> silent
    flush();
    req = 1'b1; tick(); req = 1'b0;
    chk(err, 0, "R9", "no error without resume");
    chk(vld, 0, "R10", "no grant when empty");

    finish_run();
  end
endmodule